// File: doc/BRIEF.md
# Longword SRAM Access Controller with Read-Merge-Write

This block connects one requester to an external synchronous SRAM with a 32-bit data path. The requester issues a single command that carries a byte address, a beat count of one to eight longwords, a direction and an access size. The controller then runs the transfer as a series of full-width longword bus cycles and puts a new address on the bus for each one. The memory therefore needs no burst counter of its own. The number of beats comes only from the command; the controller never lengthens a transfer.

Write data and the bit-select mask are supplied per beat. The controller shows the current beat index on `wr_beat`, and the requester answers combinationally on `wr_data` and `wr_mask`. A full-longword write goes straight out as one bus write per beat. A bit, byte or 16-bit write cannot be done in one bus cycle, so the controller first reads the containing longword, waits out the memory latency, merges the new bits into the old value and writes the whole longword back. Read data returns to the requester with a valid strobe and a last-beat flag.

Top module: `sram_rmw_ctrl`

## Requirements
- R1: After reset `busy`, `sram_cs`, `rd_valid` and `rd_last` are 0 and `cmd_ready` is 1. `cmd_ready` is 1 exactly while the controller is idle. A command is taken only in a cycle where both `cmd_valid` and `cmd_ready` are 1.
- R2: `cmd_len` holds the beat count minus one, so the values 0..7 mean 1..8 beats. A read issues N bus reads. A longword write issues N bus writes. A narrower write issues N bus reads and N bus writes.
- R3: `sram_addr` is a longword address. Beat k uses `cmd_addr[AW-1:2] + k`, and beats go out in increasing order. `sram_cs` is never high while `busy` is low.
- R4: A bus read placed on the bus in cycle t has its data on `sram_rdata` in cycle t+2. That data appears on `rd_data` with `rd_valid` high in cycle t+3. Beats return in order, and `rd_last` is high only with the final beat. `cmd_size` has no effect on reads.
- R5: With `cmd_size`=3 (longword), a write issues no bus read. Beat k writes `wr_data` exactly as presented while `wr_beat`=k.
- R6: With `cmd_size`=1 (byte), each beat reads the longword in cycle t and writes it back in cycle t+3. In the write-back, byte lane `cmd_addr[1:0]` (lane 0 = bits 7:0) is replaced by `wr_data[7:0]` and every other bit keeps its old value.
- R7: With `cmd_size`=2 (16-bit), the lane is chosen by `cmd_addr[1]` (0 = bits 15:0, 1 = bits 31:16) and filled from `wr_data[15:0]`. `cmd_addr[0]` is ignored. This uses the same read-then-write-back sequence as R6.
- R8: With `cmd_size`=0 (bit), the write-back takes `wr_data` in every bit where `wr_mask` is 1 and keeps the old value in every bit where it is 0. This also uses the read-then-write-back sequence.
- R9: The internal reads of a read-merge-write never raise `rd_valid`.
- R10: `busy` is 1 from the cycle after acceptance up to and including the cycle of the final bus write (for writes) or the cycle in which `rd_last` is 1 (for reads). It is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Controller idle, command can be taken |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_size | input | 2 | 0 bit, 1 byte, 2 16-bit, 3 longword |
| cmd_addr | input | AW | Start byte address |
| cmd_len | input | LENW | Beat count minus one |
| wr_beat | output | LENW | Beat whose write data is wanted |
| wr_data | input | 32 | Write data for beat `wr_beat` |
| wr_mask | input | 32 | Bit-select mask for bit writes |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| rd_last | output | 1 | Final beat of a read |
| busy | output | 1 | Command in progress |
| sram_cs | output | 1 | Bus cycle active |
| sram_we | output | 1 | Bus cycle is a write |
| sram_addr | output | AW-2 | Longword address |
| sram_wdata | output | 32 | Bus write data |
| sram_rdata | input | 32 | Bus read data, two cycles after address |

## Verification
The main function is exercised with every access size. Directed cases walk all four byte lanes and both halfword lanes, including odd halfword addresses, to tell correct lane steering apart from an offset or endianness slip. Longword writes and reads at the full eight-beat length check address stepping and the last-beat flag. Bit writes with random masks separate true bitwise merging from byte-granular merging. Random commands with random data, lengths and addresses then compare every bus write, every returned word and the memory contents against a shadow model, along with the exact cycles of the read return, the write-back and the fall of `busy`.

// File: rtl/sram_rmw_pkg.sv
package sram_rmw_pkg;

  localparam int LWBITS = 32;

  typedef enum logic [1:0] {
    SZ_BIT  = 2'd0,
    SZ_BYTE = 2'd1,
    SZ_HALF = 2'd2,
    SZ_WORD = 2'd3
  } acc_size_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_DRAIN,
    ST_WR,
    ST_MRG_RD,
    ST_MRG_WAIT,
    ST_FIN
  } seq_state_e;

  // bits of the longword that a write of this size replaces
  function automatic logic [LWBITS-1:0] lane_mask(acc_size_e sz, logic [1:0] lo,
                                                  logic [LWBITS-1:0] bitsel);
    logic [LWBITS-1:0] m;
    case (sz)
      SZ_BIT:  m = bitsel;
      SZ_BYTE: m = 32'h0000_00FF << {lo, 3'b000};
      SZ_HALF: m = lo[1] ? 32'hFFFF_0000 : 32'h0000_FFFF;
      default: m = '1;
    endcase
    return m;
  endfunction

  // replicate narrow data across all lanes so the mask can pick it
  function automatic logic [LWBITS-1:0] lane_data(acc_size_e sz, logic [LWBITS-1:0] d);
    logic [LWBITS-1:0] r;
    case (sz)
      SZ_BYTE: r = {4{d[7:0]}};
      SZ_HALF: r = {2{d[15:0]}};
      default: r = d;
    endcase
    return r;
  endfunction

  function automatic logic [LWBITS-1:0] merge_word(logic [LWBITS-1:0] old_w,
                                                   logic [LWBITS-1:0] new_w,
                                                   logic [LWBITS-1:0] m);
    return (new_w & m) | (old_w & ~m);
  endfunction

endpackage

// File: rtl/sram_rmw_merge.sv
module sram_rmw_merge
  import sram_rmw_pkg::*;
(
  input  acc_size_e         size,
  input  logic [1:0]        lo,
  input  logic [LWBITS-1:0] new_data,
  input  logic [LWBITS-1:0] bit_sel,
  input  logic [LWBITS-1:0] old_data,
  output logic [LWBITS-1:0] merged,
  output logic [LWBITS-1:0] sel_mask
);

  logic [LWBITS-1:0] placed;

  always_comb begin
    sel_mask = lane_mask(size, lo, bit_sel);
    placed   = lane_data(size, new_data);
    merged   = merge_word(old_data, placed, sel_mask);
  end

endmodule

// File: rtl/sram_rmw_rdpipe.sv
module sram_rmw_rdpipe
  import sram_rmw_pkg::*;
#(
  parameter int LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic              tag_last,
  input  logic              tag_merge,
  input  logic [LWBITS-1:0] bus_rdata,
  output logic              ret_valid,
  output logic              ret_merge,
  output logic              rd_valid,
  output logic [LWBITS-1:0] rd_data,
  output logic              rd_last
);

  logic [LAT-1:0] st_v, st_l, st_m;

  generate
    if (LAT == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v <= '0;
          st_l <= '0;
          st_m <= '0;
        end else begin
          st_v <= issue;
          st_l <= tag_last;
          st_m <= tag_merge;
        end
      end
    end else begin : g_shift
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          st_v <= '0;
          st_l <= '0;
          st_m <= '0;
        end else begin
          st_v <= {st_v[LAT-2:0], issue};
          st_l <= {st_l[LAT-2:0], tag_last};
          st_m <= {st_m[LAT-2:0], tag_merge};
        end
      end
    end
  endgenerate

  assign ret_valid = st_v[LAT-1];
  assign ret_merge = st_m[LAT-1];

  logic to_user;
  assign to_user = ret_valid & ~ret_merge;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_last  <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= to_user;
      rd_last  <= to_user & st_l[LAT-1];
      if (to_user) rd_data <= bus_rdata;
    end
  end

endmodule

// File: rtl/sram_rmw_seq.sv
module sram_rmw_seq
  import sram_rmw_pkg::*;
#(
  parameter int AW   = 20,
  parameter int LENW = 3,
  localparam int LAW = AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_write,
  input  acc_size_e         cmd_size,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [LENW-1:0]   cmd_len,
  input  logic [LWBITS-1:0] merged,
  input  logic              ret_valid,
  input  logic              rd_done,
  output logic              cmd_ready,
  output logic              busy,
  output logic              accept,
  output logic [LENW-1:0]   beat,
  output logic [1:0]        lo,
  output acc_size_e         size,
  output logic              merge_op,
  output logic              word_op,
  output logic              bus_cs,
  output logic              bus_we,
  output logic              bus_last,
  output logic [LAW-1:0]    bus_addr,
  output logic [LWBITS-1:0] bus_wdata
);

  seq_state_e      state;
  logic [LAW-1:0]  base;
  logic [LENW-1:0] len;
  logic            wr;
  logic            at_end;
  logic [LAW-1:0]  beat_addr;

  assign cmd_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign accept    = cmd_valid & cmd_ready;
  assign at_end    = (beat == len);
  assign beat_addr = base + LAW'(beat);
  assign merge_op  = wr & (size != SZ_WORD);
  assign word_op   = wr & (size == SZ_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      base      <= '0;
      len       <= '0;
      wr        <= 1'b0;
      lo        <= '0;
      size      <= SZ_WORD;
      beat      <= '0;
      bus_cs    <= 1'b0;
      bus_we    <= 1'b0;
      bus_last  <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
    end else begin
      bus_cs   <= 1'b0;
      bus_we   <= 1'b0;
      bus_last <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_valid) begin
            base <= cmd_addr[AW-1:2];
            lo   <= cmd_addr[1:0];
            size <= cmd_size;
            len  <= cmd_len;
            wr   <= cmd_write;
            beat <= '0;
            if (!cmd_write)             state <= ST_RD;
            else if (cmd_size == SZ_WORD) state <= ST_WR;
            else                        state <= ST_MRG_RD;
          end
        end
        ST_RD: begin
          bus_cs   <= 1'b1;
          bus_addr <= beat_addr;
          bus_last <= at_end;
          if (at_end) state <= ST_RD_DRAIN;
          else        beat  <= beat + 1'b1;
        end
        ST_RD_DRAIN: begin
          if (rd_done) state <= ST_IDLE;
        end
        ST_WR: begin
          bus_cs    <= 1'b1;
          bus_we    <= 1'b1;
          bus_addr  <= beat_addr;
          bus_wdata <= merged;
          if (at_end) state <= ST_FIN;
          else        beat  <= beat + 1'b1;
        end
        ST_MRG_RD: begin
          bus_cs   <= 1'b1;
          bus_addr <= beat_addr;
          state    <= ST_MRG_WAIT;
        end
        ST_MRG_WAIT: begin
          if (ret_valid) begin
            bus_cs    <= 1'b1;
            bus_we    <= 1'b1;
            bus_addr  <= beat_addr;
            bus_wdata <= merged;
            if (at_end) state <= ST_FIN;
            else begin
              beat  <= beat + 1'b1;
              state <= ST_MRG_RD;
            end
          end
        end
        ST_FIN:  state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sram_rmw_ctrl.sv
module sram_rmw_ctrl
  import sram_rmw_pkg::*;
#(
  parameter int AW     = 20,
  parameter int MAXLEN = 8,
  parameter int RD_LAT = 2,
  localparam int LENW  = $clog2(MAXLEN),
  localparam int LAW   = AW - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [1:0]        cmd_size,
  input  logic [AW-1:0]     cmd_addr,
  input  logic [LENW-1:0]   cmd_len,
  output logic [LENW-1:0]   wr_beat,
  input  logic [31:0]       wr_data,
  input  logic [31:0]       wr_mask,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              rd_last,
  output logic              busy,
  output logic              sram_cs,
  output logic              sram_we,
  output logic [LAW-1:0]    sram_addr,
  output logic [31:0]       sram_wdata,
  input  logic [31:0]       sram_rdata
);

  // named internal events, used by the bound checker
  logic        accept;
  logic        merge_op;
  logic        word_op;
  logic        bus_rd;
  logic        bus_last;
  logic        ret_valid;
  logic        ret_merge;
  logic        rd_done;
  logic [1:0]  lo;
  acc_size_e   size;
  logic [31:0] merged;
  logic [31:0] sel_mask;

  assign bus_rd  = sram_cs & ~sram_we;
  assign rd_done = rd_valid & rd_last;

  sram_rmw_seq #(.AW(AW), .LENW(LENW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_write (cmd_write),
    .cmd_size  (acc_size_e'(cmd_size)),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .merged    (merged),
    .ret_valid (ret_valid),
    .rd_done   (rd_done),
    .cmd_ready (cmd_ready),
    .busy      (busy),
    .accept    (accept),
    .beat      (wr_beat),
    .lo        (lo),
    .size      (size),
    .merge_op  (merge_op),
    .word_op   (word_op),
    .bus_cs    (sram_cs),
    .bus_we    (sram_we),
    .bus_last  (bus_last),
    .bus_addr  (sram_addr),
    .bus_wdata (sram_wdata)
  );

  sram_rmw_merge u_merge (
    .size     (size),
    .lo       (lo),
    .new_data (wr_data),
    .bit_sel  (wr_mask),
    .old_data (sram_rdata),
    .merged   (merged),
    .sel_mask (sel_mask)
  );

  sram_rmw_rdpipe #(.LAT(RD_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (bus_rd),
    .tag_last  (bus_last),
    .tag_merge (merge_op),
    .bus_rdata (sram_rdata),
    .ret_valid (ret_valid),
    .ret_merge (ret_merge),
    .rd_valid  (rd_valid),
    .rd_data   (rd_data),
    .rd_last   (rd_last)
  );

endmodule

// File: rtl/sram_rmw_ctrl_chk.sv
module sram_rmw_ctrl_chk #(
  parameter int AW = 20,
  localparam int LAW = AW - 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           accept,
  input logic           busy,
  input logic           sram_cs,
  input logic           sram_we,
  input logic [LAW-1:0] sram_addr,
  input logic           rd_valid,
  input logic           rd_last,
  input logic           merge_op,
  input logic           word_op
);

  p_acc_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> busy);

  p_busy_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(rd_last || (sram_cs && sram_we)));

  p_idle_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sram_cs);

  p_rd_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && !sram_we && $past(sram_cs && !sram_we)) |->
      sram_addr == $past(sram_addr) + 1'b1);

  p_rd_lat_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(sram_cs && !sram_we, 3));

  p_last_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);

  p_word_noread_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && word_op) |-> !(sram_cs && !sram_we));

  p_merge_pair_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sram_cs && sram_we && merge_op) |->
      ($past(sram_cs && !sram_we, 3) && sram_addr == $past(sram_addr, 3)));

  p_merge_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && merge_op) |-> !rd_valid);

endmodule

bind sram_rmw_ctrl sram_rmw_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .busy      (busy),
  .sram_cs   (sram_cs),
  .sram_we   (sram_we),
  .sram_addr (sram_addr),
  .rd_valid  (rd_valid),
  .rd_last   (rd_last),
  .merge_op  (merge_op),
  .word_op   (word_op)
);

// File: tb/sram_rmw_ctrl_bench.sv
module sram_rmw_ctrl_bench;
  localparam int AW = 20;
  localparam int LENW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [1:0] cmd_size = 2'd3;
  logic [AW-1:0] cmd_addr = '0;
  logic [LENW-1:0] cmd_len = '0;
  logic cmd_ready, rd_valid, rd_last, busy, sram_cs, sram_we;
  logic [LENW-1:0] wr_beat;
  logic [31:0] wr_data, wr_mask, rd_data, sram_wdata;
  logic [31:0] sram_rdata = '0;
  logic [AW-3:0] sram_addr;

  always #5 clk = ~clk;

  sram_rmw_ctrl u_sram_rmw_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_size(cmd_size), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_beat(wr_beat), .wr_data(wr_data), .wr_mask(wr_mask),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_last(rd_last), .busy(busy),
    .sram_cs(sram_cs), .sram_we(sram_we), .sram_addr(sram_addr),
    .sram_wdata(sram_wdata), .sram_rdata(sram_rdata));

  // per-beat write data offered by the requester
  logic [31:0] beat_data [0:7];
  logic [31:0] beat_mask [0:7];
  assign wr_data = beat_data[wr_beat];
  assign wr_mask = beat_mask[wr_beat];

  // memory model: two-cycle read latency
  logic [31:0] mem [0:255];
  logic [31:0] exp_mem [0:255];
  logic [31:0] mdly = '0;
  always @(posedge clk) begin
    if (sram_cs && sram_we) mem[sram_addr[7:0]] <= sram_wdata;
    mdly       <= mem[sram_addr[7:0]];
    sram_rdata <= mdly;
  end

  int checks = 0, fails = 0;
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // independent statement of the write-back value
  function automatic logic [31:0] b_expect(input logic [1:0] sz, input logic [1:0] lo,
                                           input logic [31:0] oldw, input logic [31:0] d,
                                           input logic [31:0] m);
    logic [31:0] r;
    r = oldw;
    if (sz == 2'd3) r = d;
    else if (sz == 2'd0) begin
      for (int b = 0; b < 32; b++) if (m[b]) r[b] = d[b];
    end else begin
      for (int ln = 0; ln < 4; ln++) begin
        if (sz == 2'd1 && ln == int'(lo)) r[8*ln +: 8] = d[7:0];
        if (sz == 2'd2 && (ln / 2) == int'(lo[1])) r[8*ln +: 8] = d[8*(ln % 2) +: 8];
      end
    end
    return r;
  endfunction

  function automatic string sz_tag(input logic [1:0] sz);
    case (sz)
      2'd0: return "R8";
      2'd1: return "R6";
      2'd2: return "R7";
      default: return "R5";
    endcase
  endfunction

  // monitor state
  int exp_base = 0, exp_n = 0;
  bit exp_w = 0, exp_mrg = 0;
  logic [1:0] exp_sz = 0;
  logic [31:0] exp_new [0:7];
  int rd_seen = 0, wr_seen = 0, rv_seen = 0;
  int rd_cyc [0:7];
  int last_bus = 0, last_rl = 0, idle_err = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_cs && !busy) idle_err++;
      if (sram_cs && !sram_we) begin
        chk(sram_addr == (AW-2)'(exp_base + rd_seen), "R3 read addr", 32'(sram_addr), 32'(exp_base + rd_seen));
        rd_cyc[rd_seen % 8] = cyc;
        rd_seen++;
        last_bus = cyc;
      end
      if (sram_cs && sram_we) begin
        chk(sram_addr == (AW-2)'(exp_base + wr_seen), "R3 write addr", 32'(sram_addr), 32'(exp_base + wr_seen));
        if (exp_mrg)
          chk(cyc == rd_cyc[wr_seen % 8] + 3, "R6 writeback cycle", 32'(cyc), 32'(rd_cyc[wr_seen % 8] + 3));
        chk(sram_wdata == exp_new[wr_seen % 8], sz_tag(exp_sz), sram_wdata, exp_new[wr_seen % 8]);
        wr_seen++;
        last_bus = cyc;
      end
      if (rd_valid) begin
        if (!exp_w) begin
          chk(rd_data == exp_mem[(exp_base + rv_seen) % 256], "R4 rd_data", rd_data, exp_mem[(exp_base + rv_seen) % 256]);
          chk(cyc == rd_cyc[rv_seen % 8] + 3, "R4 return cycle", 32'(cyc), 32'(rd_cyc[rv_seen % 8] + 3));
          chk(rd_last == (rv_seen == exp_n - 1), "R4 rd_last", 32'(rd_last), 32'(rv_seen == exp_n - 1));
        end
        if (rd_last) last_rl = cyc;
        rv_seen++;
      end
    end
  end

  task automatic run_cmd(input bit w, input logic [1:0] sz, input int lwa, input logic [1:0] lo, input int n);
    int guard;
    int endc;
    exp_base = lwa; exp_n = n; exp_w = w; exp_sz = sz;
    exp_mrg = w && (sz != 2'd3);
    for (int k = 0; k < 8; k++) begin
      beat_data[k] = $urandom;
      beat_mask[k] = $urandom;
      exp_new[k] = b_expect(sz, lo, exp_mem[(lwa + k) % 256], beat_data[k], beat_mask[k]);
    end
    rd_seen = 0; wr_seen = 0; rv_seen = 0;
    @(negedge clk);
    chk(cmd_ready == 1'b1, "R1 ready when idle", 32'(cmd_ready), 1);
    cmd_valid = 1'b1; cmd_write = w; cmd_size = sz; cmd_len = LENW'(n - 1);
    cmd_addr = '0; cmd_addr[9:0] = {lwa[7:0], lo};
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_size = $urandom;
    chk(busy && !cmd_ready, "R10 busy after accept", {busy, cmd_ready}, 32'b10);
    guard = 0;
    while (busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
    endc = cyc;
    chk(rd_seen == (w ? (exp_mrg ? n : 0) : n), "R2 bus read count", 32'(rd_seen), 32'(w ? (exp_mrg ? n : 0) : n));
    chk(wr_seen == (w ? n : 0), "R2 bus write count", 32'(wr_seen), 32'(w ? n : 0));
    chk(rv_seen == (w ? 0 : n), w ? "R9 no rd_valid on write" : "R4 beats returned", 32'(rv_seen), 32'(w ? 0 : n));
    chk(endc == (w ? last_bus : last_rl) + 1, "R10 busy fall", 32'(endc), 32'((w ? last_bus : last_rl) + 1));
    if (w) begin
      repeat (2) @(negedge clk);
      for (int k = 0; k < n; k++) begin
        exp_mem[(lwa + k) % 256] = exp_new[k];
        chk(mem[(lwa + k) % 256] == exp_new[k], sz_tag(sz), mem[(lwa + k) % 256], exp_new[k]);
      end
    end
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired act=%0d exp=done", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1d2c_3b4a));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'(i) * 32'h0101_0107 ^ 32'hA5C3_0000;
      exp_mem[i] = mem[i];
    end
    for (int k = 0; k < 8; k++) begin beat_data[k] = '0; beat_mask[k] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && cmd_ready && !sram_cs && !rd_valid && !rd_last, "R1 reset state",
        {busy, cmd_ready, sram_cs, rd_valid, rd_last}, 32'b01000);

    run_cmd(1, 2'd3, 16, 2'd0, 8);          // R5 full burst write
    run_cmd(0, 2'd0, 16, 2'd0, 8);          // R4 eight-beat read, size ignored
    for (int l = 0; l < 4; l++) run_cmd(1, 2'd1, 40 + l, 2'(l), 1);   // R6 lanes
    for (int l = 0; l < 4; l++) run_cmd(1, 2'd2, 50, 2'(l), 2);       // R7 lanes, bit 0 ignored
    run_cmd(1, 2'd0, 60, 2'd3, 3);          // R8 bit merge
    run_cmd(0, 2'd3, 40, 2'd0, 1);          // R4 single beat
    run_cmd(0, 2'd1, 50, 2'd2, 2);
    for (int i = 0; i < 60; i++)
      run_cmd($urandom_range(1, 0), 2'($urandom_range(3, 0)), $urandom_range(247, 0),
              2'($urandom_range(3, 0)), $urandom_range(8, 1));

    chk(idle_err == 0, "R3 bus idle while not busy", 32'(idle_err), 0);
    for (int i = 0; i < 256; i++)
      if (mem[i] != exp_mem[i]) chk(0, "R2 final memory", mem[i], exp_mem[i]);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule